// File: doc/BRIEF.md
# Shared Event Counter with Summed Steps and Ordered Loads

This block is one integer counter that several transitions of a synchronous control net act on at once. Each transition carries a fire bit. A parameter mask decides which transitions preset the counter, and each of them has its own preset value. A second mask decides which transitions move the counter up or down, and each of them has its own signed step. Any mix of these may fire in the same clock cycle.

Steps from every firing transition are added together, not ORed, so two count actions in one cycle move the counter twice. When several presets fire together, the one with the highest transition index takes effect. A preset beats all steps in that cycle. The value saturates at the signed minimum and maximum of the counter width and never wraps.

A registered signed value is output, together with a flag that is high while the value is below a threshold. The net uses that flag as a firing condition.

Top module: `shared_event_counter`

## Requirements
- R1: While reset (active low, asynchronous) is asserted, the count is 0 and the below flag is 1. The first fire vector after release acts on the value 0.
- R2: Transition i presets the counter only when fire[i] is 1 and bit i of the load mask is 1. A fired transition that is in neither mask (t6 by default) leaves the count unchanged.
- R3: When several preset transitions fire in the same cycle, the one with the highest index wins. With the defaults, t5 (preset 10) beats t1 (preset 5), and t1 beats t0 (preset 0).
- R4: If a preset and any step fire in the same cycle, the preset value is taken and the steps of that cycle are discarded.
- R5: The steps of all firing step transitions are summed into one change. With the defaults, t2 is +1 and t3 is +2, so t2 and t3 together take 3 to 6.
- R6: Steps are signed. The default t4 is -3, and t2, t3 and t4 together give a net change of 0.
- R7: A sum that goes above the largest signed value of the width (127 at 8 bits) leaves the count at that largest value.
- R8: A sum that goes below the smallest signed value (-128 at 8 bits) leaves the count at that smallest value.
- R9: The below flag equals (count < threshold), compared as signed integers (threshold 4 by default). It follows the registered count in the same cycle.
- R10: A preset value of 0 clears the count. The default t0 presets 0.
- R11: A cycle with no fire bit set, or with only unmapped bits set, keeps the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fire | input | NUM_TR | Fire bit per transition for this cycle |
| count_o | output | CNT_W | Registered signed count |
| below_o | output | 1 | High while count_o < CMP_LIMIT (signed) |

## Verification
The hardest situations to reach are the cycles where a preset, positive steps and a negative step all fire together near a saturation bound. Only then do ordering, discarding and clamping interact. A vector table first walks the hand-computed cases, including the 3-to-6 double step and the three-way preset. Directed runs then climb to the top bound and fall to the bottom bound. A long random phase follows, whose dense fire vectors often combine presets and steps, and it is compared with a model that searches presets from the top index downward.

// File: rtl/sec_pkg.sv
package sec_pkg;

  function automatic longint sat_max(input int unsigned w);
    return (longint'(1) <<< (w - 1)) - 1;
  endfunction

  function automatic longint sat_min(input int unsigned w);
    return -(longint'(1) <<< (w - 1));
  endfunction

  function automatic longint sat_clamp(input longint v, input int unsigned w);
    if (v > sat_max(w)) return sat_max(w);
    if (v < sat_min(w)) return sat_min(w);
    return v;
  endfunction

endpackage

// File: rtl/sec_load_pick.sv
module sec_load_pick #(
  parameter int unsigned NUM_TR = 7,
  parameter int unsigned CNT_W  = 8,
  parameter logic [NUM_TR-1:0] LOAD_MASK = '0,
  parameter logic [NUM_TR*CNT_W-1:0] PRESETS = '0
) (
  input  logic [NUM_TR-1:0]       fire,
  output logic                    load_hit,
  output logic signed [CNT_W-1:0] load_value
);
  logic [NUM_TR-1:0] strobe;

  for (genvar i = 0; i < NUM_TR; i++) begin : g_strobe
    if (LOAD_MASK[i]) begin : g_on
      assign strobe[i] = fire[i];
    end else begin : g_off
      assign strobe[i] = 1'b0;
    end
  end

  assign load_hit = |strobe;

  // ascending walk: a later index overrides an earlier one
  always_comb begin
    load_value = '0;
    for (int i = 0; i < NUM_TR; i++) begin
      if (strobe[i]) load_value = $signed(PRESETS[i*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/sec_step_sum.sv
module sec_step_sum #(
  parameter int unsigned NUM_TR = 7,
  parameter int unsigned STEP_W = 4,
  parameter int unsigned SUM_W  = 8,
  parameter logic [NUM_TR-1:0] UPDN_MASK = '0,
  parameter logic [NUM_TR*STEP_W-1:0] STEPS = '0
) (
  input  logic [NUM_TR-1:0]       fire,
  output logic                    step_any,
  output logic signed [SUM_W-1:0] step_total
);
  logic signed [SUM_W-1:0] term [NUM_TR];

  for (genvar i = 0; i < NUM_TR; i++) begin : g_term
    if (UPDN_MASK[i]) begin : g_on
      assign term[i] = fire[i] ? SUM_W'($signed(STEPS[i*STEP_W +: STEP_W])) : '0;
    end else begin : g_off
      assign term[i] = '0;
    end
  end

  assign step_any = |(fire & UPDN_MASK);

  always_comb begin
    step_total = '0;
    for (int i = 0; i < NUM_TR; i++) step_total = step_total + term[i];
  end
endmodule

// File: rtl/sec_next_calc.sv
module sec_next_calc
  import sec_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned SUM_W = 8
) (
  input  logic signed [CNT_W-1:0] cur,
  input  logic                    load_hit,
  input  logic signed [CNT_W-1:0] load_value,
  input  logic                    step_any,
  input  logic signed [SUM_W-1:0] step_total,
  output logic signed [CNT_W-1:0] nxt,
  output logic                    sat_hi,
  output logic                    sat_lo
);
  longint raw;
  longint clamped;

  always_comb begin
    raw     = longint'(cur) + longint'(step_total);
    clamped = sat_clamp(raw, CNT_W);
    sat_hi  = 1'b0;
    sat_lo  = 1'b0;
    if (load_hit) begin
      nxt = load_value;
    end else if (step_any) begin
      nxt    = clamped[CNT_W-1:0];
      sat_hi = raw > sat_max(CNT_W);
      sat_lo = raw < sat_min(CNT_W);
    end else begin
      nxt = cur;
    end
  end
endmodule

// File: rtl/shared_event_counter.sv
module shared_event_counter #(
  parameter int unsigned NUM_TR = 7,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned STEP_W = 4,
  parameter int signed   CMP_LIMIT = 4,
  parameter logic [NUM_TR-1:0] LOAD_MASK = 7'b0100011,
  parameter logic [NUM_TR-1:0] UPDN_MASK = 7'b0011100,
  parameter logic [NUM_TR*CNT_W-1:0] PRESETS =
    {8'd0, 8'd10, 8'd0, 8'd0, 8'd0, 8'd5, 8'd0},
  parameter logic [NUM_TR*STEP_W-1:0] STEPS =
    {4'd0, 4'd0, 4'hD, 4'd2, 4'd1, 4'd0, 4'd0}
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_TR-1:0]       fire,
  output logic signed [CNT_W-1:0] count_o,
  output logic                    below_o
);
  localparam int unsigned SUM_W = STEP_W + $clog2(NUM_TR + 1) + 1;

  logic                    load_hit;
  logic signed [CNT_W-1:0] load_value;
  logic                    step_any;
  logic signed [SUM_W-1:0] step_total;
  logic signed [CNT_W-1:0] nxt;
  logic                    sat_hi;
  logic                    sat_lo;
  logic signed [CNT_W-1:0] count_q;

  sec_load_pick #(
    .NUM_TR(NUM_TR), .CNT_W(CNT_W), .LOAD_MASK(LOAD_MASK), .PRESETS(PRESETS)
  ) u_load (
    .fire(fire), .load_hit(load_hit), .load_value(load_value)
  );

  sec_step_sum #(
    .NUM_TR(NUM_TR), .STEP_W(STEP_W), .SUM_W(SUM_W),
    .UPDN_MASK(UPDN_MASK), .STEPS(STEPS)
  ) u_sum (
    .fire(fire), .step_any(step_any), .step_total(step_total)
  );

  sec_next_calc #(
    .CNT_W(CNT_W), .SUM_W(SUM_W)
  ) u_next (
    .cur(count_q), .load_hit(load_hit), .load_value(load_value),
    .step_any(step_any), .step_total(step_total),
    .nxt(nxt), .sat_hi(sat_hi), .sat_lo(sat_lo)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= nxt;
  end

  assign count_o = count_q;
  assign below_o = longint'(count_q) < longint'(CMP_LIMIT);
endmodule

// File: rtl/sec_checker.sv
module sec_checker
  import sec_pkg::*;
#(
  parameter int unsigned NUM_TR = 7,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned SUM_W  = 8,
  parameter logic [NUM_TR-1:0] LOAD_MASK = '0,
  parameter logic [NUM_TR-1:0] UPDN_MASK = '0
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_TR-1:0]       fire,
  input logic signed [CNT_W-1:0] count_o,
  input logic                    load_hit,
  input logic signed [CNT_W-1:0] load_value,
  input logic                    step_any,
  input logic signed [SUM_W-1:0] step_total,
  input logic                    sat_hi,
  input logic                    sat_lo
);
  p_load_taken_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_hit |=> count_o == $past(load_value));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((fire & (LOAD_MASK | UPDN_MASK)) == '0) |=> $stable(count_o));

  p_sum_applied_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_any && !load_hit && !sat_hi && !sat_lo) |=>
      longint'(count_o) == longint'($past(count_o)) + longint'($past(step_total)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi |=> longint'(count_o) == sat_max(CNT_W));

  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo |=> longint'(count_o) == sat_min(CNT_W));

  p_one_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi && sat_lo));
endmodule

bind shared_event_counter sec_checker #(
  .NUM_TR(NUM_TR), .CNT_W(CNT_W), .SUM_W(SUM_W),
  .LOAD_MASK(LOAD_MASK), .UPDN_MASK(UPDN_MASK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fire(fire), .count_o(count_o),
  .load_hit(load_hit), .load_value(load_value),
  .step_any(step_any), .step_total(step_total),
  .sat_hi(sat_hi), .sat_lo(sat_lo)
);

// File: tb/sim_shared_event_counter.sv
module sim_shared_event_counter;
  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [6:0]        fire = '0;
  logic signed [7:0] count_o;
  logic              below_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  // bench view of the default mapping, index 0 first
  localparam bit IS_LD [7] = '{1, 1, 0, 0, 0, 1, 0};
  localparam int LD_VAL[7] = '{0, 5, 0, 0, 0, 10, 0};
  localparam bit IS_UD [7] = '{0, 0, 1, 1, 1, 0, 0};
  localparam int STEPV [7] = '{0, 0, 1, 2, -3, 0, 0};

  // {fire[6:0], expected count[7:0]}
  localparam logic [14:0] VEC [14] = '{
    {7'b0000010, 8'd5},    // R2 t1 preset
    {7'b0001100, 8'd8},    // R5 summed
    {7'b0010000, 8'd5},    // R6 negative step
    {7'b1000000, 8'd5},    // R2 unmapped t6
    {7'b0100010, 8'd10},   // R3 t5 over t1
    {7'b0000101, 8'd0},    // R4 R10 preset wins over step
    {7'b0010000, 8'hFD},   // R6 -3
    {7'b0011100, 8'hFD},   // R6 net zero
    {7'b0100011, 8'd10},   // R3 three presets
    {7'b0000001, 8'd0},    // R10 clear
    {7'b0001000, 8'd2},
    {7'b0000100, 8'd3},
    {7'b0001100, 8'd6},    // R5 3 -> 6
    {7'b0000000, 8'd6}     // R11 hold
  };

  shared_event_counter u0 (
    .clk(clk), .rst_n(rst_n), .fire(fire), .count_o(count_o), .below_o(below_o)
  );

  always #5 clk = ~clk;

  function automatic int ref_next(input int cur, input logic [6:0] f);
    int acc;
    for (int i = 6; i >= 0; i--) begin
      if (f[i] && IS_LD[i]) return LD_VAL[i];
    end
    acc = cur;
    for (int i = 0; i < 7; i++) if (f[i] && IS_UD[i]) acc += STEPV[i];
    if (acc > 127)  acc = 127;
    if (acc < -128) acc = -128;
    return acc;
  endfunction

  task automatic check(input string req, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic check_both(input string req, input int exp);
    check(req, int'(count_o), exp);
    check({req, "/R9"}, int'(below_o), (exp < 4) ? 1 : 0);
  endtask

  // drive away from the edge, sample 1 ns after the edge that registers it
  task automatic apply(input logic [6:0] f);
    fire = f;
    @(posedge clk);
    #1;
  endtask

  initial begin
    int model;
    #23;
    check("R1 reset count", int'(count_o), 0);
    check("R1 reset below", int'(below_o), 1);
    @(posedge clk); #1;
    check("R1 held in reset", int'(count_o), 0);
    rst_n = 1'b1;
    #2;
    model = 0;

    for (int k = 0; k < 14; k++) begin
      apply(VEC[k][14:8]);
      model = ref_next(model, VEC[k][14:8]);
      check("R2-table entry", int'(count_o), int'($signed(VEC[k][7:0])));
      check_both("R5 model", model);
    end

    // R7 climb to the top bound
    apply(7'b0100000);
    model = 10;
    for (int k = 0; k < 62; k++) begin
      apply(7'b0001100);
      model = ref_next(model, 7'b0001100);
    end
    check_both("R7 saturate high", 127);
    apply(7'b0000100);
    check_both("R7 stays at max", 127);
    apply(7'b0010000);
    check_both("R7 leaves max", 124);

    // R8 fall to the bottom bound
    for (int k = 0; k < 90; k++) apply(7'b0010000);
    check_both("R8 saturate low", -128);
    apply(7'b0010100);
    check_both("R8 stays at min", -128);
    apply(7'b0001000);
    check_both("R8 leaves min", -126);
    model = -126;

    // random phase with dense vectors
    for (int k = 0; k < 3000; k++) begin
      logic [6:0] f;
      f = 7'($urandom);
      if (k % 5 == 0) f = f & 7'b0011100;
      apply(f);
      model = ref_next(model, f);
      check_both("R4 random", model);
    end

    // R1 reset mid run
    apply(7'b0100000);
    rst_n = 1'b0;
    #1;
    check_both("R1 async reset", 0);
    fire = 7'b0001000;
    #10;
    rst_n = 1'b1;
    #4;
    @(posedge clk); #1;
    check_both("R1 first after release", 2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule